// File: doc/BRIEF.md
# Counted Configuration Clock Burst Generator

This block drives a configuration clock pin with a finite, software-programmed number of pulses. Software writes a pulse count into a count register over a simple 32-bit register bus. The block then toggles its clock output once per pulse: one internal clock cycle high, then one cycle low. When the last pulse finishes, a sticky completion flag is raised in a status register. Software clears that flag by writing a one to it.

A typical use is a configuration controller that needs fixed clock bursts at set points in its sequence. Examples are a few hundred pulses to flush a target's error state, or about two thousand pulses before data streaming begins. Software clears the flag, writes the count, then polls the flag. The pulses still outstanding can be read back from the count register at any time.

Top module: `cfgclk_burst_gen`

## Requirements
- R1: After reset, the clock output is low, the count register reads 0 and the status register reads 0.
- R2: A write of N to the count register (byte offset 0x08) produces exactly N output pulses. The output goes high in the second cycle after the write cycle. Each pulse is high for one cycle and then low for at least one cycle.
- R3: Status bit 0 (byte offset 0x0C) rises on the same clock edge that ends the high phase of the last pulse. It then stays set until it is cleared. All other status bits read 0.
- R4: A status write with bit 0 set clears the done flag. If a burst completes on that same edge, the flag is set instead.
- R5: A count write during a running burst abandons the old burst. It forces the output low and clears the done flag, and the new count is then produced in full.
- R6: A read of the count register returns the number of pulses whose high phase has not yet ended.
- R7: A count write of 0 sets the done flag on the write edge and produces no pulse.
- R8: A status write with bit 0 clear leaves the done flag unchanged. Writes to any other offset change nothing, and reads of them return 0. Address bits 1:0 are ignored.
- R9: While no pulses are outstanding, the clock output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; output pulses are derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational by default) |
| cfg_clk_o | output | 1 | Configuration clock output |

## Verification
The embedded assertions check the pulse shape, the one-per-pulse decrement of the outstanding count, the output staying low with nothing outstanding, the reload on a count write, and the set, clear and hold rules of the done flag. Several things only the bench scenarios can show: that a burst of 256 or 2047 yields that exact number of pulses, that a restart mid-burst delivers only the new count, and that a zero count flags completion with no pulse. The same holds for ignored status and unmapped writes being invisible at the register interface. A behavioural model in the bench predicts the output pin and the read data for every cycle.

// File: rtl/cfgclk_pkg.sv
package cfgclk_pkg;
   // decoded register command for one bus cycle
   typedef struct packed {
      logic load;   // count register written
      logic clr;    // status bit 0 written with one
   } cfgclk_cmd_t;
endpackage

// File: rtl/cfgclk_regs.sv
module cfgclk_regs
   import cfgclk_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter int CNT_W      = 32,
   parameter int COUNT_OFS  = 8,
   parameter int STATUS_OFS = 12,
   parameter bit RDATA_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wen,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  rem_i,
   input  logic              done_i,
   output cfgclk_cmd_t       cmd_o,
   output logic [CNT_W-1:0]  load_val_o,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int WIDX_W = ADDR_W - 2;
   localparam logic [WIDX_W-1:0] CNT_IDX = WIDX_W'(COUNT_OFS >> 2);
   localparam logic [WIDX_W-1:0] STS_IDX = WIDX_W'(STATUS_OFS >> 2);

   logic [WIDX_W-1:0] word;
   logic [DATA_W-1:0] rd_mux;
   logic              unused_bits;

   assign word        = bus_addr[ADDR_W-1:2];
   assign unused_bits = ^{bus_addr[1:0], bus_wdata};

   always_comb begin
      cmd_o.load = bus_wen && (word == CNT_IDX);
      cmd_o.clr  = bus_wen && (word == STS_IDX) && bus_wdata[0];
   end

   assign load_val_o = bus_wdata[CNT_W-1:0];

   always_comb begin
      rd_mux = '0;
      if (word == CNT_IDX)      rd_mux = DATA_W'(rem_i);
      else if (word == STS_IDX) rd_mux[0] = done_i;
   end

   generate
      if (RDATA_FLOP) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bus_rdata <= '0;
            else        bus_rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/cfgclk_engine.sv
module cfgclk_engine #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] rem_o,
   output logic             hi_o,
   output logic             finish_o
);
   logic [CNT_W-1:0] rem_q;
   logic             hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         hi_q  <= 1'b0;
      end else if (load_i) begin
         rem_q <= load_val_i;
         hi_q  <= 1'b0;
      end else if (hi_q) begin
         rem_q <= rem_q - 1'b1;
         hi_q  <= 1'b0;
      end else if (rem_q != '0) begin
         hi_q  <= 1'b1;
      end
   end

   assign finish_o = load_i ? (load_val_i == '0)
                            : (hi_q && (rem_q == CNT_W'(1)));
   assign rem_o = rem_q;
   assign hi_o  = hi_q;

   // R2
   pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_q && !load_i |=> !hi_q);
   // R6
   rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_q && !load_i |=> rem_q == $past(rem_q) - 1'b1);
   // R9
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rem_q == '0 |-> !hi_q);
   // R5
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (rem_q == $past(load_val_i)) && !hi_q);
endmodule

// File: rtl/cfgclk_done_flag.sv
module cfgclk_done_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic done_o
);
   logic done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     done_q <= 1'b0;
      else if (set_i) done_q <= 1'b1;
      else if (clr_i) done_q <= 1'b0;
   end

   assign done_o = done_q;

   // R3
   set_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> done_q);
   // R4
   clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i && !set_i |=> !done_q);
   // R8
   hold_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !set_i && !clr_i |=> $stable(done_q));
endmodule

// File: rtl/cfgclk_burst_gen.sv
module cfgclk_burst_gen
   import cfgclk_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter int CNT_W      = 32,
   parameter int COUNT_OFS  = 8,
   parameter int STATUS_OFS = 12,
   parameter bit RDATA_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wen,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cfg_clk_o
);
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must be between 1 and DATA_W");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
      if ((COUNT_OFS % 4) != 0 || (STATUS_OFS % 4) != 0 || COUNT_OFS == STATUS_OFS) begin : g_bad_ofs
         $error("register offsets must be distinct and word aligned");
      end
   endgenerate

   cfgclk_cmd_t      cmd;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] rem;
   logic             finish;
   logic             done;

   cfgclk_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .COUNT_OFS(COUNT_OFS), .STATUS_OFS(STATUS_OFS), .RDATA_FLOP(RDATA_FLOP)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rem_i(rem), .done_i(done), .cmd_o(cmd),
      .load_val_o(load_val), .bus_rdata(bus_rdata)
   );

   cfgclk_engine #(.CNT_W(CNT_W)) engine_i (
      .clk(clk), .rst_n(rst_n), .load_i(cmd.load), .load_val_i(load_val),
      .rem_o(rem), .hi_o(cfg_clk_o), .finish_o(finish)
   );

   cfgclk_done_flag done_i (
      .clk(clk), .rst_n(rst_n), .set_i(finish),
      .clr_i(cmd.clr | cmd.load), .done_o(done)
   );

   // R8
   status_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wen && !cmd.load && !cmd.clr && !finish |=> $stable(done));
endmodule

// File: tb/cfgclk_burst_gen_tb_top.sv
module cfgclk_burst_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CNT = 8'h08;
   localparam logic [7:0] A_STS = 8'h0C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wen = 1'b0;
   logic [7:0]  bus_addr = A_CNT;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cfg_clk_o;

   int  n_chk = 0;
   int  n_fail = 0;
   int  pulses = 0;
   bit  prev_clk_o = 1'b0;
   bit  finished = 1'b0;
   logic [7:0] mon_addr = A_CNT;

   // behavioural reference state
   longint ref_rem = 0;
   bit     ref_hi = 0;
   bit     ref_done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgclk_burst_gen dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_clk_o(cfg_clk_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference model, advanced on every rising edge
   always @(posedge clk) begin
      bit wr_cnt, wr_clr, fin;
      if (!rst_n) begin
         ref_rem = 0; ref_hi = 0; ref_done = 0;
      end else begin
         wr_cnt = bus_wen && (bus_addr[7:2] == 6'd2);
         wr_clr = bus_wen && (bus_addr[7:2] == 6'd3) && bus_wdata[0];
         fin = 0;
         if (wr_cnt) begin
            fin = (bus_wdata == 0);
            ref_rem = bus_wdata; ref_hi = 0;
         end else if (ref_hi) begin
            if (ref_rem == 1) fin = 1;
            ref_rem--; ref_hi = 0;
         end else if (ref_rem > 0) begin
            ref_hi = 1;
         end
         if (fin) ref_done = 1;
         else if (wr_clr || wr_cnt) ref_done = 0;
      end
   end

   // per-cycle compare, away from the rising edge
   always @(negedge clk) begin
      longint exp_rd;
      if (!finished) begin
         chk(cfg_clk_o === ref_hi, "R2 clock output", cfg_clk_o, ref_hi);
         if (bus_addr[7:2] == 6'd2) begin
            exp_rd = ref_rem;
            chk(bus_rdata === 32'(exp_rd), "R6 count readback", bus_rdata, exp_rd);
         end else if (bus_addr[7:2] == 6'd3) begin
            exp_rd = ref_done;
            chk(bus_rdata === 32'(exp_rd), "R3 status readback", bus_rdata, exp_rd);
         end else begin
            chk(bus_rdata === 32'd0, "R8 unmapped read", bus_rdata, 0);
         end
         if (cfg_clk_o && !prev_clk_o) pulses++;
         prev_clk_o = cfg_clk_o;
      end
   end

   task automatic cyc(input int n = 1);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc();
      bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
      cyc();
      bus_wen = 1'b0; bus_addr = mon_addr; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #2;
      d = bus_rdata;
   endtask

   task automatic burst(input int n, input string req);
      logic [31:0] v;
      wr(A_STS, 32'h1);
      pulses = 0;
      wr(A_CNT, 32'(n));
      cyc(2 * n + 3);
      chk(pulses == n, req, pulses, n);
      rd(A_STS, v);
      chk(v == 32'h1, {req, " done"}, v, 1);
      bus_addr = mon_addr;
   endtask

   initial begin
      logic [31:0] v;
      cyc(3);
      // R1 reset state
      chk(cfg_clk_o == 1'b0, "R1 output low in reset", cfg_clk_o, 0);
      rd(A_CNT, v); chk(v == 0, "R1 count after reset", v, 0);
      rd(A_STS, v); chk(v == 0, "R1 status after reset", v, 0);
      rst_n = 1'b1;
      bus_addr = mon_addr;
      cyc(4);
      chk(pulses == 0, "R9 idle output low", pulses, 0);

      // R2 / R3 bursts of several lengths
      burst(1, "R2 single pulse");
      burst(5, "R2 short burst");
      burst(256, "R2 flush burst");
      burst(2047, "R2 pre-stream burst");

      // R4 write-one clears done
      wr(A_STS, 32'h1);
      rd(A_STS, v); chk(v == 0, "R4 done cleared", v, 0);

      // R8 status write with bit0 clear is ignored
      burst(3, "R2 burst before ignored clear");
      wr(A_STS, 32'hFFFF_FFFE);
      rd(A_STS, v); chk(v == 1, "R8 zero-bit write keeps done", v, 1);
      // R8 write to unmapped offset ignored, bits 1:0 ignored
      wr(8'h10, 32'd77);
      rd(A_CNT, v); chk(v == 0, "R8 unmapped write no effect", v, 0);
      rd(8'h0F, v); chk(v == 1, "R8 addr low bits ignored", v, 1);
      bus_addr = mon_addr;

      // R7 zero count
      pulses = 0;
      wr(A_STS, 32'h1);
      wr(A_CNT, 32'd0);
      rd(A_STS, v); chk(v == 1, "R7 zero count sets done", v, 1);
      cyc(6);
      chk(pulses == 0, "R7 zero count no pulses", pulses, 0);
      bus_addr = mon_addr;

      // R5 restart mid-burst
      wr(A_STS, 32'h1);
      wr(A_CNT, 32'd10);
      cyc(5);
      pulses = 0;
      wr(A_CNT, 32'd3);
      chk(cfg_clk_o == 1'b0, "R5 output low after restart", cfg_clk_o, 0);
      rd(A_STS, v); chk(v == 0, "R5 done clear during new burst", v, 0);
      rd(A_CNT, v); chk(v == 3, "R6 count after restart", v, 3);
      bus_addr = mon_addr;
      cyc(10);
      chk(pulses == 3, "R5 only new count produced", pulses, 3);
      rd(A_STS, v); chk(v == 1, "R5 done after new burst", v, 1);

      // R5 restart clears a set done flag
      wr(A_CNT, 32'd2);
      rd(A_STS, v); chk(v == 0, "R5 count write clears done", v, 0);
      bus_addr = mon_addr;
      cyc(8);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule